// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the fetch stage of a small processor core and decides when the core leaves normal flow for a handler and when it comes back. Each cycle it looks at three kinds of request. The first is a synchronous program exception raised by the pipeline. The other two are asynchronous: an external interrupt level and a decrementer underflow pulse. It also watches a return-from-interrupt strobe. The controller owns the machine state word, which the core loads through a write port.

When a request is accepted, the controller does the following:
- copies the current instruction address into the address save register;
- copies the whole state word into the state save register, in the same cycle;
- sets supervisor mode and clears the external-enable bit;
- issues a one-cycle fetch redirect to the handler vector.

A return strobe does the reverse. It reloads the state word from the state save register and redirects fetch to the saved address.

Top module: `exc_unit`

## Requirements
- R1: After reset the state word reads 0x0000_4000 (supervisor bit 14 set, external-enable bit 15 clear, all other bits 0). Both save registers read 0 and `redirect_o` is 0.
- R2: On an accepted exception, `save_addr_o` takes the value `pc_i` had in the accepting cycle, and `save_state_o` takes the state word of that same cycle. Both are visible one cycle later.
- R3: On an accepted exception, the next state word keeps every bit except bit 14, which is set, and bit 15, which is cleared. `redirect_o` pulses high for exactly one cycle.
- R4: The redirect target is VEC_BASE (default 0x1000) plus an offset that depends on the cause: 0x700 for a synchronous request, 0x500 for the external interrupt, 0x900 for the decrementer.
- R5: The external interrupt and the decrementer are accepted only while state bit 15 is 1. A synchronous request is accepted whatever the value of bit 15.
- R6: When a synchronous request and an enabled asynchronous request arrive in the same cycle, the synchronous one is taken.
- R7: When the external interrupt and the decrementer are both pending and enabled, the external interrupt is taken. A decrementer pulse stays pending until it is taken, including while bit 15 is 0.
- R8: A return strobe reloads the state word from `save_state_o` and redirects fetch to `save_addr_o` one cycle later. Neither save register changes.
- R9: In a cycle with the return strobe high, no exception is accepted, even a synchronous one.
- R10: `state_we_i` loads `state_wdata_i` into the state word only in a cycle with neither an accepted exception nor a return strobe. In those two cases the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | AW | Address of the current instruction |
| sync_req_i | input | 1 | Synchronous program exception request |
| ext_irq_i | input | 1 | External interrupt level |
| dec_req_i | input | 1 | Decrementer underflow pulse |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| state_we_i | input | 1 | State word write enable |
| state_wdata_i | input | SW | State word write data |
| redirect_o | output | 1 | One-cycle fetch redirect |
| target_o | output | AW | Redirect address, valid while `redirect_o` is high |
| state_o | output | SW | Current machine state word |
| save_addr_o | output | AW | Saved return address |
| save_state_o | output | SW | Saved state word |

## Verification
Every result the controller produces is due on the first clock edge after the cycle that holds the stimulus. This covers the redirect pulse, the target, the new state word and both save registers. A decrementer pulse that is held back is taken on the first edge at which bit 15 is 1 and no higher-priority request is present.

The driver applies inputs at the falling edge. It then pushes one expected snapshot for the following rising edge. The monitor compares that snapshot 2 ns after the rising edge, so each check lands exactly one register stage after its stimulus. Pending-decrementer cases are checked over the several cycles it waits.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_SYNC = 2'd1,
    CAUSE_EXT  = 2'd2,
    CAUSE_DEC  = 2'd3
  } cause_e;

  localparam int unsigned OFF_SYNC = 'h700;
  localparam int unsigned OFF_EXT  = 'h500;
  localparam int unsigned OFF_DEC  = 'h900;
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic   rfi_i,
  input  logic   sync_i,
  input  logic   ext_i,
  input  logic   dec_i,
  input  logic   ee_i,
  output logic   take_o,
  output cause_e cause_o
);
  always_comb begin
    cause_o = CAUSE_NONE;
    if (!rfi_i) begin
      if (sync_i)             cause_o = CAUSE_SYNC;
      else if (ee_i && ext_i) cause_o = CAUSE_EXT;
      else if (ee_i && dec_i) cause_o = CAUSE_DEC;
    end
    take_o = (cause_o != CAUSE_NONE);
  end
endmodule

// File: rtl/exc_vec.sv
module exc_vec
  import exc_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = AW'('h1000)
) (
  input  cause_e        cause_i,
  output logic [AW-1:0] vec_o
);
  logic [AW-1:0] off;
  always_comb begin
    unique case (cause_i)
      CAUSE_SYNC: off = AW'(OFF_SYNC);
      CAUSE_EXT:  off = AW'(OFF_EXT);
      CAUSE_DEC:  off = AW'(OFF_DEC);
      default:    off = '0;
    endcase
    vec_o = VEC_BASE + off;
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned SW      = 32,
  parameter int unsigned EE_BIT  = 15,
  parameter int unsigned SUP_BIT = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pc_i,
  input  logic          take_i,
  input  cause_e        cause_i,
  input  logic [AW-1:0] vec_i,
  input  logic          rfi_i,
  input  logic          dec_eff_i,
  input  logic          we_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] state_o,
  output logic [AW-1:0] srr0_o,
  output logic [SW-1:0] srr1_o,
  output logic          dec_pend_o,
  output logic          redirect_o,
  output logic [AW-1:0] target_o
);
  localparam logic [SW-1:0] SUP_MASK  = SW'(1) << SUP_BIT;
  localparam logic [SW-1:0] EE_MASK   = SW'(1) << EE_BIT;
  localparam logic [SW-1:0] RST_STATE = SUP_MASK;

  logic [SW-1:0] state_q, srr1_q;
  logic [AW-1:0] srr0_q, target_q;
  logic          redirect_q, dec_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RST_STATE;
      srr0_q     <= '0;
      srr1_q     <= '0;
      target_q   <= '0;
      redirect_q <= 1'b0;
      dec_pend_q <= 1'b0;
    end else begin
      redirect_q <= rfi_i || take_i;
      dec_pend_q <= dec_eff_i && !(take_i && cause_i == CAUSE_DEC);
      if (rfi_i) begin
        state_q  <= srr1_q;
        target_q <= srr0_q;
      end else if (take_i) begin
        srr0_q   <= pc_i;
        srr1_q   <= state_q;
        state_q  <= (state_q | SUP_MASK) & ~EE_MASK;
        target_q <= vec_i;
      end else if (we_i) begin
        state_q  <= wdata_i;
      end
    end
  end

  assign state_o    = state_q;
  assign srr0_o     = srr0_q;
  assign srr1_o     = srr1_q;
  assign dec_pend_o = dec_pend_q;
  assign redirect_o = redirect_q;
  assign target_o   = target_q;

  assert_save_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (srr0_q == $past(pc_i)) && (srr1_q == $past(state_q)));
  assert_entry_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> state_q[SUP_BIT] && !state_q[EE_BIT] && redirect_q);
  assert_redirect_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !rfi_i) |=> !redirect_q);
  assert_return_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfi_i |=> (state_q == $past(srr1_q)) && (target_q == $past(srr0_q)) && redirect_q);
  assert_save_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfi_i |=> $stable(srr0_q) && $stable(srr1_q));
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   SW       = 32,
  parameter int unsigned   EE_BIT   = 15,
  parameter int unsigned   SUP_BIT  = 14,
  parameter logic [AW-1:0] VEC_BASE = AW'('h1000)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pc_i,
  input  logic          sync_req_i,
  input  logic          ext_irq_i,
  input  logic          dec_req_i,
  input  logic          rfi_i,
  input  logic          state_we_i,
  input  logic [SW-1:0] state_wdata_i,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic [SW-1:0] state_o,
  output logic [AW-1:0] save_addr_o,
  output logic [SW-1:0] save_state_o
);
  logic          take, dec_pend, dec_eff;
  cause_e        cause;
  logic [AW-1:0] vec;

  assign dec_eff = dec_pend || dec_req_i;

  exc_arb u_arb (
    .rfi_i   (rfi_i),
    .sync_i  (sync_req_i),
    .ext_i   (ext_irq_i),
    .dec_i   (dec_eff),
    .ee_i    (state_o[EE_BIT]),
    .take_o  (take),
    .cause_o (cause)
  );

  exc_vec #(.AW(AW), .VEC_BASE(VEC_BASE)) u_vec (
    .cause_i (cause),
    .vec_o   (vec)
  );

  exc_regs #(.AW(AW), .SW(SW), .EE_BIT(EE_BIT), .SUP_BIT(SUP_BIT)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_i       (pc_i),
    .take_i     (take),
    .cause_i    (cause),
    .vec_i      (vec),
    .rfi_i      (rfi_i),
    .dec_eff_i  (dec_eff),
    .we_i       (state_we_i),
    .wdata_i    (state_wdata_i),
    .state_o    (state_o),
    .srr0_o     (save_addr_o),
    .srr1_o     (save_state_o),
    .dec_pend_o (dec_pend),
    .redirect_o (redirect_o),
    .target_o   (target_o)
  );

  assert_async_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cause != CAUSE_SYNC) |-> state_o[EE_BIT]);
  assert_sync_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_req_i && !rfi_i) |-> (take && cause == CAUSE_SYNC));
  assert_ext_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && ext_irq_i && !sync_req_i) |-> cause == CAUSE_EXT);
  assert_rfi_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfi_i |-> !take);
endmodule

// File: tb/exc_unit_tb_top.sv
module exc_unit_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned SW = 32;
  localparam logic [SW-1:0] EE  = 32'h0000_8000;
  localparam logic [SW-1:0] SUP = 32'h0000_4000;
  localparam logic [AW-1:0] BASE = 32'h0000_1000;

  typedef struct packed {
    logic          redirect;
    logic [AW-1:0] target;
    logic [SW-1:0] state;
    logic [AW-1:0] srr0;
    logic [SW-1:0] srr1;
  } snap_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic sync_req_i = 0, ext_irq_i = 0, dec_req_i = 0, rfi_i = 0, state_we_i = 0;
  logic [SW-1:0] state_wdata_i = '0;
  logic redirect_o;
  logic [AW-1:0] target_o, save_addr_o;
  logic [SW-1:0] state_o, save_state_o;

  int checks = 0, failures = 0;
  snap_t exp_q[$];
  string tag_q[$];

  // reference state derived from the requirements
  logic [SW-1:0] m_state = SUP, m_srr1 = '0;
  logic [AW-1:0] m_srr0 = '0;
  logic          m_pend = 1'b0;

  always #5 clk_i = ~clk_i;

  exc_unit dut_i (
    .clk_i, .rst_ni, .pc_i, .sync_req_i, .ext_irq_i, .dec_req_i, .rfi_i,
    .state_we_i, .state_wdata_i, .redirect_o, .target_o, .state_o,
    .save_addr_o, .save_state_o
  );

  task automatic step(input logic [AW-1:0] pc, input logic sy, input logic ex,
                      input logic dc, input logic rf, input logic we,
                      input logic [SW-1:0] wd, input string tag);
    snap_t e;
    logic dece;
    @(negedge clk_i);
    pc_i = pc; sync_req_i = sy; ext_irq_i = ex; dec_req_i = dc; rfi_i = rf;
    state_we_i = we; state_wdata_i = wd;
    dece = m_pend | dc;
    e.redirect = 1'b0;
    e.target   = '0;
    if (rf) begin
      e.redirect = 1'b1; e.target = m_srr0;
      m_state = m_srr1; m_pend = dece;
    end else if (sy || (m_state[15] && (ex || dece))) begin
      e.redirect = 1'b1;
      if (sy)      e.target = BASE + 32'h700;
      else if (ex) e.target = BASE + 32'h500;
      else         e.target = BASE + 32'h900;
      m_pend = (!sy && !ex) ? 1'b0 : dece;
      m_srr0 = pc; m_srr1 = m_state;
      m_state = (m_state | SUP) & ~EE;
    end else begin
      if (we) m_state = wd;
      m_pend = dece;
    end
    e.state = m_state; e.srr0 = m_srr0; e.srr1 = m_srr1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        snap_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a.redirect = redirect_o;
        a.target   = redirect_o ? target_o : '0;
        a.state = state_o; a.srr0 = save_addr_o; a.srr1 = save_state_o;
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s: actual redir=%0b tgt=%h st=%h s0=%h s1=%h expected redir=%0b tgt=%h st=%h s0=%h s1=%h",
                   t, a.redirect, a.target, a.state, a.srr0, a.srr1,
                   e.redirect, e.target, e.state, e.srr0, e.srr1);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    checks++; // R1 reset state
    if (state_o !== SUP || save_addr_o !== '0 || save_state_o !== '0 || redirect_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: actual st=%h s0=%h s1=%h redir=%0b expected st=%h s0=0 s1=0 redir=0",
               state_o, save_addr_o, save_state_o, redirect_o, SUP);
    end
    step(32'h080, 0, 1, 0, 0, 0, '0, "R5 ext masked");
    step(32'h084, 0, 0, 0, 0, 1, 32'h0000_8001, "R10 state write");
    step(32'h100, 1, 1, 0, 0, 0, '0, "R6 sync beats ext / R2 / R4 sync");
    step(32'h104, 0, 1, 0, 0, 0, '0, "R3 ee cleared, R5 masked");
    step(32'h108, 1, 0, 0, 1, 0, '0, "R9 rfi suppresses sync / R8");
    step(32'h200, 0, 1, 1, 0, 0, '0, "R7 ext beats dec / R4 ext");
    step(32'h204, 0, 0, 0, 1, 0, '0, "R8 return");
    step(32'h300, 0, 0, 0, 0, 0, '0, "R7 dec pending taken / R4 dec");
    step(32'h304, 0, 0, 0, 0, 0, '0, "R3 single pulse");
    step(32'h400, 1, 0, 0, 0, 0, '0, "R5 sync while ee=0");
    step(32'h404, 0, 0, 0, 1, 0, '0, "R8 return ee=0");
    step(32'h408, 0, 0, 0, 0, 1, 32'h0000_8001, "R10 set ee");
    step(32'h500, 0, 1, 0, 0, 1, 32'h0000_0000, "R10 write dropped on accept");
    step(32'h504, 0, 0, 0, 1, 1, 32'h0000_0000, "R10 write dropped on rfi");
    step(32'h508, 0, 0, 0, 0, 1, 32'h0000_0000, "R10 clear ee");
    step(32'h50c, 0, 0, 1, 0, 0, '0, "R7 dec held while masked");
    step(32'h510, 0, 0, 0, 0, 0, '0, "R7 dec still held");
    step(32'h514, 0, 0, 0, 0, 1, 32'h0000_8000, "R10 enable ee");
    step(32'h600, 0, 0, 0, 0, 0, '0, "R7 held dec taken");
    step(32'h604, 0, 0, 0, 0, 0, '0, "R3 idle after entry");
    @(negedge clk_i);
    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule